// File: doc/BRIEF.md
# Stereo Soft-Mute and Fixed Attenuation Gain Stage

This block scales a stereo stream of signed PCM samples that arrives at the sample rate, one left/right pair per valid strobe. Two active-low controls shape the level. One requests mute. The other requests a fixed 12 dB cut. Mute never switches the level abruptly. A gain counter walks one step per accepted sample between full scale and zero, so the level fades out over a fixed number of samples and fades back in over the same count. If the request changes partway through a fade, the fade turns around from wherever it is.

Each sample is multiplied by the current gain and divided by the full-scale gain. When attenuation is requested, the same result is also divided by four. The division rounds toward zero, so a fully muted stream is exactly zero and negative samples never leave a residue of -1. The result is registered. It appears one clock after its input, together with an output strobe.

Top module: `smute_atten_top`

## Requirements
- R1: While reset is asserted (rst_n low), out_valid is 0, both outputs are 0, and the gain is set to full scale (1024).
- R2: out_valid is in_valid delayed by exactly one clock. In a cycle where in_valid was 0, out_left and out_right keep their previous values.
- R3: While mute_n is 0, each valid sample lowers the gain by one until it reaches 0. From full scale, the 1025th muted sample is the first one output at zero gain.
- R4: While mute_n is 1, each valid sample raises the gain by one until it reaches full scale (1024).
- R5: A change of mute_n in the middle of a fade reverses the direction from the current gain value, with no jump.
- R6: With atten_n at 1, each output equals sample × g / 1024 rounded toward zero. Here g is the gain before that sample's own step.
- R7: With atten_n at 0, each output equals sample × g / 4096 rounded toward zero (a 12 dB cut), using a single rounding.
- R8: At gain 0, both outputs are exactly 0 for any input sample, including the most negative value.
- R9: The gain does not change in cycles where in_valid is 0.
- R10: At full gain with atten_n at 1, the output equals the input exactly, including both extreme values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | A sample pair is present this cycle |
| in_left | input | 20 | Left sample, two's complement |
| in_right | input | 20 | Right sample, two's complement |
| mute_n | input | 1 | Mute request, active low, sampled with in_valid |
| atten_n | input | 1 | 12 dB cut request, active low, sampled with in_valid |
| out_valid | output | 1 | Scaled pair present |
| out_left | output | 20 | Scaled left sample |
| out_right | output | 20 | Scaled right sample |

## Verification
The only internal state is the gain counter. A wrong gain shows up as a scaled output that differs from the bench's model on the very next strobe, provided the sample is large enough to resolve one gain step. Full-scale samples resolve that step at every gain. A counter that stops early or overshoots at either end only shows at the moment a fade ends. For that reason the bench runs complete 1024-sample fades and reversals that start mid-fade, and it checks that idle cycles leave both the outputs and the fade position untouched.

// File: rtl/smute_pkg.sv
package smute_pkg;

    // Direction the gain counter takes on the current cycle
    typedef enum logic [1:0] {
        RAMP_HOLD = 2'd0,
        RAMP_DOWN = 2'd1,
        RAMP_UP   = 2'd2
    } ramp_dir_e;

endpackage

// File: rtl/smute_gain_ramp.sv
module smute_gain_ramp
    import smute_pkg::*;
#(
    parameter int RAMP_LOG2 = 10,
    parameter int GAIN_W    = RAMP_LOG2 + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              step,
    input  logic              mute_req,
    output logic [GAIN_W-1:0] gain
);

    localparam logic [GAIN_W-1:0] GAIN_FULL = {1'b1, {RAMP_LOG2{1'b0}}};

    typedef struct packed {
        logic [GAIN_W-1:0] gain;
    } ramp_state_t;

    ramp_state_t state_d, state_q;
    ramp_dir_e   dir;

    always_comb begin
        state_d = state_q;
        dir     = RAMP_HOLD;
        if (step) begin
            if (mute_req && state_q.gain != '0) begin
                dir = RAMP_DOWN;
            end else if (!mute_req && state_q.gain != GAIN_FULL) begin
                dir = RAMP_UP;
            end
        end
        case (dir)
            RAMP_DOWN: state_d.gain = state_q.gain - 1'b1;
            RAMP_UP:   state_d.gain = state_q.gain + 1'b1;
            default:   state_d.gain = state_q.gain;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q.gain <= GAIN_FULL;
        end else begin
            state_q <= state_d;
        end
    end

    assign gain = state_q.gain;

endmodule

// File: rtl/smute_scaler.sv
module smute_scaler #(
    parameter int DATA_W      = 20,
    parameter int RAMP_LOG2   = 10,
    parameter int GAIN_W      = RAMP_LOG2 + 1,
    parameter int ATTEN_SHIFT = 2
) (
    input  logic signed [DATA_W-1:0] smp_in,
    input  logic        [GAIN_W-1:0] gain,
    input  logic                     atten,
    output logic signed [DATA_W-1:0] smp_out
);

    localparam int PROD_W = DATA_W + GAIN_W + 1;
    localparam int SH_W   = 6;
    localparam logic [SH_W-1:0] SH_BASE  = SH_W'(RAMP_LOG2);
    localparam logic [SH_W-1:0] SH_EXTRA = SH_W'(ATTEN_SHIFT);

    logic signed [PROD_W-1:0] smp_ext;
    logic signed [PROD_W-1:0] gain_ext;
    logic signed [PROD_W-1:0] product;
    logic signed [PROD_W-1:0] bias;
    logic signed [PROD_W-1:0] quotient;
    logic        [SH_W-1:0]   shamt;

    always_comb begin
        smp_ext  = {{(PROD_W-DATA_W){smp_in[DATA_W-1]}}, smp_in};
        gain_ext = {{(PROD_W-GAIN_W){1'b0}}, gain};
        product  = smp_ext * gain_ext;
        shamt    = atten ? (SH_BASE + SH_EXTRA) : SH_BASE;
        // Negative products get 2^shamt-1 added so the shift truncates toward zero
        if (product[PROD_W-1]) begin
            bias = (PROD_W'(1) << shamt) - PROD_W'(1);
        end else begin
            bias = '0;
        end
        quotient = (product + bias) >>> shamt;
        smp_out  = quotient[DATA_W-1:0];
    end

endmodule

// File: rtl/smute_atten_top.sv
module smute_atten_top #(
    parameter int DATA_W      = 20,
    parameter int RAMP_LOG2   = 10,
    parameter int ATTEN_SHIFT = 2
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     in_valid,
    input  logic signed [DATA_W-1:0] in_left,
    input  logic signed [DATA_W-1:0] in_right,
    input  logic                     mute_n,
    input  logic                     atten_n,
    output logic                     out_valid,
    output logic signed [DATA_W-1:0] out_left,
    output logic signed [DATA_W-1:0] out_right
);

    localparam int GAIN_W = RAMP_LOG2 + 1;
    localparam int N_CH   = 2;

    typedef struct packed {
        logic                     vld;
        logic signed [DATA_W-1:0] left;
        logic signed [DATA_W-1:0] right;
    } out_state_t;

    out_state_t               out_d, out_q;
    logic        [GAIN_W-1:0] gain_w;
    logic signed [DATA_W-1:0] ch_in  [N_CH];
    logic signed [DATA_W-1:0] ch_out [N_CH];

    smute_gain_ramp #(
        .RAMP_LOG2 (RAMP_LOG2),
        .GAIN_W    (GAIN_W)
    ) i_ramp (
        .clk      (clk),
        .rst_n    (rst_n),
        .step     (in_valid),
        .mute_req (!mute_n),
        .gain     (gain_w)
    );

    assign ch_in[0] = in_left;
    assign ch_in[1] = in_right;

    for (genvar ch = 0; ch < N_CH; ch++) begin : g_chan
        smute_scaler #(
            .DATA_W      (DATA_W),
            .RAMP_LOG2   (RAMP_LOG2),
            .GAIN_W      (GAIN_W),
            .ATTEN_SHIFT (ATTEN_SHIFT)
        ) i_scaler (
            .smp_in  (ch_in[ch]),
            .gain    (gain_w),
            .atten   (!atten_n),
            .smp_out (ch_out[ch])
        );
    end

    always_comb begin
        out_d     = out_q;
        out_d.vld = in_valid;
        if (in_valid) begin
            out_d.left  = ch_out[0];
            out_d.right = ch_out[1];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_q <= '0;
        end else begin
            out_q <= out_d;
        end
    end

    assign out_valid = out_q.vld;
    assign out_left  = out_q.left;
    assign out_right = out_q.right;

endmodule

// File: rtl/smute_atten_chk.sv
module smute_atten_chk #(
    parameter int DATA_W    = 20,
    parameter int RAMP_LOG2 = 10,
    parameter int GAIN_W    = RAMP_LOG2 + 1
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic              mute_n,
    input logic              out_valid,
    input logic [DATA_W-1:0] out_left,
    input logic [DATA_W-1:0] out_right,
    input logic [GAIN_W-1:0] gain
);

    localparam logic [GAIN_W-1:0] GAIN_FULL = {1'b1, {RAMP_LOG2{1'b0}}};

    // R2
    strobe_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    // R2
    strobe_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!out_valid && $stable(out_left) && $stable(out_right)));

    // R3
    fade_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !mute_n && gain != '0) |=> (gain == $past(gain) - 1'b1));

    // R4
    fade_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && mute_n && gain != GAIN_FULL) |=> (gain == $past(gain) + 1'b1));

    // R4
    gain_ceiling_chk: assert property (@(posedge clk) disable iff (!rst_n)
        gain <= GAIN_FULL);

    // R8
    silent_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && gain == '0) |=> (out_left == '0 && out_right == '0));

    // R9
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(gain));

endmodule

bind smute_atten_top smute_atten_chk #(
    .DATA_W    (DATA_W),
    .RAMP_LOG2 (RAMP_LOG2),
    .GAIN_W    (GAIN_W)
) i_smute_atten_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .mute_n    (mute_n),
    .out_valid (out_valid),
    .out_left  (out_left),
    .out_right (out_right),
    .gain      (gain_w)
);

// File: tb/test_smute_atten_top.sv
`timescale 1ns/1ps
module test_smute_atten_top;

    localparam int DW   = 20;
    localparam int FULL = 1024;
    localparam logic signed [DW-1:0] S_MAX = 20'sh7FFFF;
    localparam logic signed [DW-1:0] S_MIN = 20'sh80000;

    logic                 clk = 1'b0;
    logic                 rst_n;
    logic                 in_valid;
    logic signed [DW-1:0] in_left, in_right;
    logic                 mute_n, atten_n;
    logic                 out_valid;
    logic signed [DW-1:0] out_left, out_right;

    int n_total = 0;
    int n_fail  = 0;
    int model_g = FULL;
    logic signed [DW-1:0] last_l = '0, last_r = '0;
    bit idle_before = 1'b0;

    always #2 clk = ~clk;

    smute_atten_top i_smute_atten_top (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
        .in_left(in_left), .in_right(in_right),
        .mute_n(mute_n), .atten_n(atten_n),
        .out_valid(out_valid), .out_left(out_left), .out_right(out_right)
    );

    function automatic logic signed [DW-1:0] expect_scaled(
        input logic signed [DW-1:0] s, input int g, input bit att);
        longint p, q;
        int sh;
        p  = longint'(s) * longint'(g);
        sh = att ? 12 : 10;
        if (p < 0) q = -((-p) >>> sh);
        else       q = p >>> sh;
        return DW'(q);
    endfunction

    task automatic check(input string req, input longint act, input longint exp_v);
        n_total++;
        if (act != exp_v) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp_v, $time);
        end
    endtask

    // Caller is at a falling edge; result is checked on the next falling edge
    task automatic send(input string tag, input logic signed [DW-1:0] l,
                        input logic signed [DW-1:0] r, input bit mute, input bit att);
        string t;
        logic signed [DW-1:0] el, er;
        el = expect_scaled(l, model_g, att);
        er = expect_scaled(r, model_g, att);
        if (tag != "") t = tag;
        else if (model_g == 0) t = "R8";
        else if (idle_before) t = "R9";
        else if (att) t = "R7";
        else if (model_g == FULL) t = "R10";
        else t = "R6";
        in_valid = 1'b1; in_left = l; in_right = r;
        mute_n = !mute; atten_n = !att;
        @(negedge clk);
        in_valid = 1'b0;
        check("R2", longint'(out_valid), 1);
        check(t, longint'(out_left), longint'(el));
        check(t, longint'(out_right), longint'(er));
        last_l = el; last_r = er;
        idle_before = 1'b0;
        if (mute && model_g > 0) model_g--;
        else if (!mute && model_g < FULL) model_g++;
    endtask

    task automatic idle(input bit mute);
        in_valid = 1'b0; mute_n = !mute;
        in_left = DW'($urandom); in_right = DW'($urandom);
        @(negedge clk);
        check("R2", longint'(out_valid), 0);
        check("R2", longint'(out_left), longint'(last_l));
        check("R2", longint'(out_right), longint'(last_r));
        idle_before = 1'b1;
    endtask

    function automatic logic signed [DW-1:0] rnd_smp();
        return DW'($urandom);
    endfunction

    initial begin
        #800000;
        n_fail++; n_total++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_total - n_fail, n_total);
        $finish;
    end

    initial begin
        bit mute_r, att_r;
        int hold;
        void'($urandom(32'd4242));
        rst_n = 1'b0; in_valid = 1'b0; in_left = '0; in_right = '0;
        mute_n = 1'b1; atten_n = 1'b1;
        repeat (3) @(negedge clk);
        check("R1", longint'(out_valid), 0);
        check("R1", longint'(out_left), 0);
        check("R1", longint'(out_right), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R1, R10: full gain straight after reset, extremes pass unchanged
        send("R1",  S_MAX, S_MIN, 1'b0, 1'b0);
        send("R10", S_MIN, S_MAX, 1'b0, 1'b0);
        send("R10", -20'sd1, 20'sd1, 1'b0, 1'b0);

        // R3: complete fade out, full-scale inputs resolve every step
        for (int i = 0; i < FULL; i++) send("R3", S_MAX, S_MIN, 1'b1, 1'b0);
        send("R8", S_MIN, S_MAX, 1'b1, 1'b0);
        send("R8", -20'sd1, S_MIN, 1'b1, 1'b1);

        // R9: idle cycles at the bottom leave the gain at zero even when unmuted
        idle(1'b0); idle(1'b0);
        send("R9", S_MAX, S_MIN, 1'b0, 1'b0);

        // R4: complete fade in
        for (int i = 0; i < FULL; i++) send("R4", S_MIN, S_MAX, 1'b0, 1'b0);
        send("R10", S_MAX, S_MIN, 1'b0, 1'b0);

        // R5: reverse mid-fade in both directions
        for (int i = 0; i < 300; i++) send("R3", S_MAX, S_MIN, 1'b1, 1'b0);
        for (int i = 0; i < 120; i++) send("R5", S_MAX, S_MIN, 1'b0, 1'b0);
        for (int i = 0; i < 60;  i++) send("R5", S_MIN, S_MAX, 1'b1, 1'b0);

        // R7: attenuation with small negatives rounding toward zero
        send("R7", -20'sd3, 20'sd3, 1'b0, 1'b1);
        send("R7", S_MIN, S_MAX, 1'b0, 1'b1);
        for (int i = 0; i < 40; i++) send("R7", rnd_smp(), rnd_smp(), 1'b0, 1'b1);

        // Mixed random traffic with mute bursts, attenuation and gaps
        mute_r = 1'b0; hold = 0;
        for (int i = 0; i < 6000; i++) begin
            if (hold == 0) begin
                mute_r = ($urandom % 2) == 1;
                hold   = 1 + ($urandom % 1400);
            end
            hold--;
            att_r = ($urandom % 3) == 0;
            if (($urandom % 8) == 0) idle(mute_r);
            else send("", rnd_smp(), rnd_smp(), mute_r, att_r);
        end

        $display("%0d/%0d checks passed", n_total - n_fail, n_total);
        $finish;
    end

endmodule